// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is a write-only serial control port. A host loads 16-bit words into a small bank of 11-bit configuration registers using an active-low enable, a serial clock and a data line. Each word carries a 5-bit register address followed by 11 data bits, and both are sent most significant bit first. The three serial lines and an active-high hardware reset pin come from outside the system clock domain. They pass through a two-flop synchronizer, and falling serial-clock edges are found in the system clock domain.

Two registers are implemented: a power register at address 0x00 and a mode register at address 0x0D. The block merges these registers with static configuration pins, whose levels arrive already decoded, to drive the effective controls. These controls are three power-down outputs and a six-bit mode field. A bit in the power register resets the whole bank and is never retained. An override bit in the mode register chooses whether the mode field comes from the register or from the pins.

Top module: `serial_cfg_port`

## Requirements
- R1: After rst_ni, both registers hold zero. pdn_glob_o is 0, pdn_a_o and pdn_b_o follow their pins, and mode_o equals pin_mode_i.
- R2: While sen_ni is low, sdata_i is sampled on each falling edge of sclk_i. The first 5 bits form the address and the next 11 form the data, both MSB first. The word is committed on the 16th falling edge, and the result shows at the outputs within 4 system clocks after that edge reaches the inputs.
- R3: Several 16-bit words sent within one low period of sen_ni are each committed in turn.
- R4: When sen_ni rises, any partial word is discarded. This includes leftover bits after a whole number of words. The next enable-low period starts a fresh word.
- R5: A high level on hw_rst_i returns both registers to zero.
- R6: A committed write to address 0x00 with data bit 10 set clears both registers, whatever the other bits of that word hold. Bit 10 is not retained, so a later write to 0x00 with bit 10 clear stores its data normally.
- R7: pdn_glob_o equals bit 0 of register 0x00. pdn_a_o is the OR of pdn_a_pin_i and bit 2 of register 0x00. pdn_b_o is the OR of pdn_b_pin_i and bit 3 of register 0x00.
- R8: When bit 10 of register 0x0D is 1, mode_o equals bits 5..0 of that register; otherwise mode_o equals pin_mode_i. The mode bits are: bit 0 two-wire lanes, bit 1 single-edge bit clock, bit 2 16x serialization, bit 3 LSB first, bit 4 capture on rising edge, bit 5 coarse gain.
- R9: Writes to any address other than 0x00 and 0x0D change no output.
- R10: Falling edges of sclk_i while sen_ni is high neither shift data nor commit a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| sen_ni | input | 1 | Serial enable, active low |
| sclk_i | input | 1 | Serial clock, data taken on falling edges |
| sdata_i | input | 1 | Serial data |
| hw_rst_i | input | 1 | Register reset pin, active high |
| pdn_a_pin_i | input | 1 | Channel A power-down pin level |
| pdn_b_pin_i | input | 1 | Channel B power-down pin level |
| pin_mode_i | input | 6 | Mode field decoded from configuration pins |
| pdn_a_o | output | 1 | Effective channel A power-down |
| pdn_b_o | output | 1 | Effective channel B power-down |
| pdn_glob_o | output | 1 | Effective global power-down |
| mode_o | output | 6 | Effective mode field |

## Verification
A falling serial-clock edge, or a rise of hw_rst_i, passes two synchronizer flops before the registers act on it. The register then updates on the third system clock edge after the input changes, and the outputs follow combinationally. Pin inputs reach the outputs in the same cycle. The reference model applies a register change at the moment the stimulus is driven and opens a 4-cycle window. During that window each falling-clock comparison accepts either the old or the new expected value. Outside the window, and for every pin change, only the new value passes.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  localparam int ADDR_W      = 5;
  localparam int DATA_W      = 11;
  localparam int MODE_W      = 6;
  localparam int SYNC_STAGES = 2;
  localparam int NUM_REGS    = 2;

  localparam logic [ADDR_W-1:0] ADDR_PWR  = 5'h00;
  localparam logic [ADDR_W-1:0] ADDR_MODE = 5'h0D;

  localparam logic [DATA_W-1:0] MASK_PWR  = 11'h00D;
  localparam logic [DATA_W-1:0] MASK_MODE = 11'h43F;

  localparam int SRST_BIT    = 10;
  localparam int OVRD_BIT    = 10;
  localparam int PD_GLOB_BIT = 0;
  localparam int PD_A_BIT    = 2;
  localparam int PD_B_BIT    = 3;

  localparam int IDX_PWR  = 0;
  localparam int IDX_MODE = 1;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int             W       = 4,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= RST_VAL;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= RST_VAL;
      else         stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/scfg_shift.sv
module scfg_shift #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 11
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sen_i,   // synchronized, active high = idle
  input  logic                        sclk_i,
  input  logic                        sdata_i,
  input  logic                        clr_i,
  output logic                        wr_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [DATA_W-1:0]           data_o,
  output logic [$clog2(ADDR_W+DATA_W)-1:0] cnt_o
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic              sclk_d;
  logic [WORD_W-2:0] sh;
  logic [CNT_W-1:0]  cnt;
  logic              fall;
  logic [WORD_W-1:0] word;

  assign fall = sclk_d & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d <= 1'b1;
      sh     <= '0;
      cnt    <= '0;
    end else begin
      sclk_d <= sclk_i;
      if (sen_i || clr_i) begin
        cnt <= '0;
      end else if (fall) begin
        sh  <= {sh[WORD_W-3:0], sdata_i};
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
      end
    end
  end

  assign word   = {sh, sdata_i};
  assign wr_o   = fall & ~sen_i & ~clr_i & (cnt == LAST);
  assign addr_o = word[WORD_W-1 -: ADDR_W];
  assign data_o = word[DATA_W-1:0];
  assign cnt_o  = cnt;
endmodule

// File: rtl/scfg_bank.sv
module scfg_bank #(
  parameter int ADDR_W   = 5,
  parameter int DATA_W   = 11,
  parameter int NUM_REGS = 2,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] ADDRS = '0,
  parameter logic [NUM_REGS-1:0][DATA_W-1:0] MASKS = '0,
  parameter logic [ADDR_W-1:0] SRST_ADDR = '0,
  parameter int SRST_BIT = 10
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             hw_clr_i,
  input  logic                             wr_i,
  input  logic [ADDR_W-1:0]                addr_i,
  input  logic [DATA_W-1:0]                data_i,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_o
);
  logic soft_clr;
  // reset bit acts on the bank and is never stored
  assign soft_clr = wr_i && (addr_i == SRST_ADDR) && data_i[SRST_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_o[i] <= '0;
      else if (hw_clr_i || soft_clr)        regs_o[i] <= '0;
      else if (wr_i && addr_i == ADDRS[i])  regs_o[i] <= data_i & MASKS[i];
    end
  end
endmodule

// File: rtl/scfg_resolve.sv
module scfg_resolve #(
  parameter int MODE_W = 6
) (
  input  logic              pd_glob_reg_i,
  input  logic              pd_a_reg_i,
  input  logic              pd_b_reg_i,
  input  logic              ovrd_i,
  input  logic [MODE_W-1:0] mode_reg_i,
  input  logic              pdn_a_pin_i,
  input  logic              pdn_b_pin_i,
  input  logic [MODE_W-1:0] pin_mode_i,
  output logic              pdn_a_o,
  output logic              pdn_b_o,
  output logic              pdn_glob_o,
  output logic [MODE_W-1:0] mode_o
);
  always_comb begin
    pdn_a_o    = pdn_a_pin_i | pd_a_reg_i;
    pdn_b_o    = pdn_b_pin_i | pd_b_reg_i;
    pdn_glob_o = pd_glob_reg_i;
    mode_o     = ovrd_i ? mode_reg_i : pin_mode_i;
  end
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scfg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sen_ni,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              hw_rst_i,
  input  logic              pdn_a_pin_i,
  input  logic              pdn_b_pin_i,
  input  logic [MODE_W-1:0] pin_mode_i,
  output logic              pdn_a_o,
  output logic              pdn_b_o,
  output logic              pdn_glob_o,
  output logic [MODE_W-1:0] mode_o
);
  localparam int WORD_W = ADDR_W + DATA_W;
  localparam int CNT_W  = $clog2(WORD_W);
  localparam logic [NUM_REGS-1:0][ADDR_W-1:0] ADDRS = {ADDR_MODE, ADDR_PWR};
  localparam logic [NUM_REGS-1:0][DATA_W-1:0] MASKS = {MASK_MODE, MASK_PWR};

  logic [3:0]  sync_q;
  logic        sen_s, sclk_s, sdata_s, hw_rst_s;
  logic        wr;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [CNT_W-1:0]  bit_cnt;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs;
  logic [DATA_W-1:0] pwr_reg, mode_reg;

  scfg_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({hw_rst_i, sdata_i, sclk_i, sen_ni}),
    .q_o    (sync_q)
  );
  assign {hw_rst_s, sdata_s, sclk_s, sen_s} = sync_q;

  scfg_shift #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sen_i   (sen_s),
    .sclk_i  (sclk_s),
    .sdata_i (sdata_s),
    .clr_i   (hw_rst_s),
    .wr_o    (wr),
    .addr_o  (wr_addr),
    .data_o  (wr_data),
    .cnt_o   (bit_cnt)
  );

  scfg_bank #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
    .ADDRS(ADDRS), .MASKS(MASKS), .SRST_ADDR(ADDR_PWR), .SRST_BIT(SRST_BIT)
  ) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_clr_i (hw_rst_s),
    .wr_i     (wr),
    .addr_i   (wr_addr),
    .data_i   (wr_data),
    .regs_o   (regs)
  );

  assign pwr_reg  = regs[IDX_PWR];
  assign mode_reg = regs[IDX_MODE];

  scfg_resolve #(.MODE_W(MODE_W)) u_resolve (
    .pd_glob_reg_i (pwr_reg[PD_GLOB_BIT]),
    .pd_a_reg_i    (pwr_reg[PD_A_BIT]),
    .pd_b_reg_i    (pwr_reg[PD_B_BIT]),
    .ovrd_i        (mode_reg[OVRD_BIT]),
    .mode_reg_i    (mode_reg[MODE_W-1:0]),
    .pdn_a_pin_i   (pdn_a_pin_i),
    .pdn_b_pin_i   (pdn_b_pin_i),
    .pin_mode_i    (pin_mode_i),
    .pdn_a_o       (pdn_a_o),
    .pdn_b_o       (pdn_b_o),
    .pdn_glob_o    (pdn_glob_o),
    .mode_o        (mode_o)
  );
endmodule

// File: rtl/scfg_checker.sv
module scfg_checker
  import scfg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sen_s,
  input logic              hw_rst_s,
  input logic              wr,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic [DATA_W-1:0] pwr_reg,
  input logic [DATA_W-1:0] mode_reg,
  input logic              pdn_a_pin_i,
  input logic              pdn_b_pin_i,
  input logic [MODE_W-1:0] pin_mode_i,
  input logic              pdn_a_o,
  input logic              pdn_b_o,
  input logic [MODE_W-1:0] mode_o
);
  logic known_addr;
  assign known_addr = (wr_addr == ADDR_PWR) || (wr_addr == ADDR_MODE);

  assert_mode_commit_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wr_addr == ADDR_MODE && !hw_rst_s) |=> mode_reg == ($past(wr_data) & MASK_MODE));

  assert_idle_clears_cnt_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sen_s |=> bit_cnt == '0);

  assert_hw_reset_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_s |=> (pwr_reg == '0 && mode_reg == '0));

  assert_soft_reset_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && wr_addr == ADDR_PWR && wr_data[SRST_BIT]) |=> (pwr_reg == '0 && mode_reg == '0));

  assert_pdn_a_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_a_pin_i |-> pdn_a_o);

  assert_pdn_b_pin_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pdn_b_pin_i |-> pdn_b_o);

  assert_pin_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_reg[OVRD_BIT] |-> mode_o == pin_mode_i);

  assert_ignore_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && !known_addr && !hw_rst_s) |=> ($stable(pwr_reg) && $stable(mode_reg)));

  assert_no_write_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |-> !sen_s);
endmodule

bind serial_cfg_port scfg_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sen_s       (sen_s),
  .hw_rst_s    (hw_rst_s),
  .wr          (wr),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .bit_cnt     (bit_cnt),
  .pwr_reg     (pwr_reg),
  .mode_reg    (mode_reg),
  .pdn_a_pin_i (pdn_a_pin_i),
  .pdn_b_pin_i (pdn_b_pin_i),
  .pin_mode_i  (pin_mode_i),
  .pdn_a_o     (pdn_a_o),
  .pdn_b_o     (pdn_b_o),
  .mode_o      (mode_o)
);

// File: tb/sim_serial_cfg_port.sv
module sim_serial_cfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_SCLK  = 4;
  localparam int WIN        = 4;
  localparam int WDOG       = 200000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sen_ni = 1'b1, sclk = 1'b1, sdata = 1'b0, hw_rst = 1'b0;
  logic pin_a = 1'b0, pin_b = 1'b0;
  logic [5:0] pin_mode = 6'b010110;
  logic pdn_a, pdn_b, pdn_glob;
  logic [5:0] mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_cfg_port u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sen_ni(sen_ni), .sclk_i(sclk), .sdata_i(sdata),
    .hw_rst_i(hw_rst), .pdn_a_pin_i(pin_a), .pdn_b_pin_i(pin_b), .pin_mode_i(pin_mode),
    .pdn_a_o(pdn_a), .pdn_b_o(pdn_b), .pdn_glob_o(pdn_glob), .mode_o(mode)
  );

  int n_chk = 0, n_fail = 0;
  string cur_req = "R1";
  logic [10:0] m_pwr = '0, m_mode = '0;
  logic [8:0] exp_prev = '0;
  int win = 0;
  int mcnt = 0;
  logic [15:0] mword = '0;
  bit comparing = 0, done = 0;

  function automatic logic [8:0] expv();
    logic [5:0] m;
    m = m_mode[10] ? m_mode[5:0] : pin_mode;
    return {pin_a | m_pwr[2], pin_b | m_pwr[3], m_pwr[0], m};
  endfunction

  function automatic logic [8:0] actv();
    return {pdn_a, pdn_b, pdn_glob, mode};
  endfunction

  // every-clock comparison against the model
  always @(negedge clk) begin
    if (comparing && !done) begin
      logic [8:0] a, e;
      a = actv(); e = expv();
      n_chk++;
      if (a !== e && !(win > 0 && a === exp_prev)) begin
        n_fail++;
        $display("FAIL %s: act=%b exp=%b t=%0t", cur_req, a, e, $time);
      end
      if (win > 0) win--;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check_now(input string req);
    logic [8:0] a, e;
    wait_clk(WIN + 2);
    a = actv(); e = expv();
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s: act=%b exp=%b", req, a, e);
    end
  endtask

  task automatic model_write(input logic [15:0] w);
    logic [4:0] ad; logic [10:0] d;
    ad = w[15:11]; d = w[10:0];
    exp_prev = expv();
    if (ad == 5'h00) begin
      if (d[10]) begin m_pwr = '0; m_mode = '0; end
      else m_pwr = d & 11'h00D;
    end else if (ad == 5'h0D) begin
      m_mode = d & 11'h43F;
    end
    win = WIN;
  endtask

  task automatic send_bit(input logic b, input bit enabled);
    sdata = b;
    wait_clk(HALF_SCLK);
    sclk = 1'b0;
    if (enabled) begin
      mword = {mword[14:0], b};
      mcnt++;
      if (mcnt == 16) begin model_write(mword); mcnt = 0; end
    end
    wait_clk(HALF_SCLK);
    sclk = 1'b1;
  endtask

  task automatic send_bits(input logic [63:0] v, input int n);
    wait_clk(1);
    sen_ni = 1'b0; mcnt = 0;
    wait_clk(HALF_SCLK);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i], 1'b1);
    wait_clk(HALF_SCLK);
    sen_ni = 1'b1; mcnt = 0;
    wait_clk(HALF_SCLK);
  endtask

  task automatic write_reg(input logic [4:0] ad, input logic [10:0] d);
    send_bits({48'd0, ad, d}, 16);
  endtask

  task automatic set_pins(input logic a, input logic b, input logic [5:0] m);
    pin_a = a; pin_b = b; pin_mode = m; win = 0;
  endtask

  initial begin
    #(CLK_PERIOD * WDOG);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    wait_clk(3);
    rst_ni = 1'b1;
    wait_clk(1);
    comparing = 1;
    cur_req = "R1"; check_now("R1");

    cur_req = "R2"; write_reg(5'h0D, 11'h400 | 11'h029);
    check_now("R2"); check_now("R8");

    cur_req = "R7"; write_reg(5'h00, 11'h00D); check_now("R7");
    set_pins(1'b1, 1'b0, pin_mode); write_reg(5'h00, 11'h001); check_now("R7");
    set_pins(1'b0, 1'b1, pin_mode); wait_clk(2); check_now("R7");
    set_pins(1'b0, 1'b0, pin_mode);

    cur_req = "R3"; send_bits({32'd0, 5'h00, 11'h008, 5'h0D, 11'h00A}, 32);
    check_now("R3");

    cur_req = "R8"; set_pins(1'b0, 1'b0, 6'b101101); check_now("R8");
    write_reg(5'h0D, 11'h43F); set_pins(1'b0, 1'b0, 6'b000000); check_now("R8");

    cur_req = "R4"; send_bits({57'd0, 7'b1111111}, 7);
    write_reg(5'h00, 11'h004); check_now("R4");
    send_bits({44'd0, 5'h0D, 11'h415, 4'b1111}, 20); check_now("R4");
    write_reg(5'h00, 11'h000); check_now("R4");

    cur_req = "R9"; write_reg(5'h05, 11'h7FF); write_reg(5'h1F, 11'h7FF);
    write_reg(5'h0C, 11'h7FF); check_now("R9");

    cur_req = "R10";
    for (int i = 15; i >= 0; i--) send_bit(((16'h000D >> i) & 1) != 0, 1'b0);
    check_now("R10");

    cur_req = "R6"; write_reg(5'h00, 11'h00D); write_reg(5'h00, 11'h40D);
    check_now("R6");
    write_reg(5'h00, 11'h001); check_now("R6");

    cur_req = "R5"; write_reg(5'h0D, 11'h412); check_now("R5");
    exp_prev = expv(); m_pwr = '0; m_mode = '0; hw_rst = 1'b1; win = WIN;
    wait_clk(3); hw_rst = 1'b0;
    check_now("R5");
    write_reg(5'h00, 11'h008); check_now("R5");

    wait_clk(10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule